// File: doc/BRIEF.md
# Saturating Signed Add/Subtract Unit

This block is a registered arithmetic stage that adds or subtracts two signed two's complement operands. Addition returns A plus B. Subtraction returns B minus A, so A is always the subtrahend. When the true mathematical result fits the operand width, the wrapped result is delivered. When it does not fit, the output clamps to the most positive or most negative representable value instead of wrapping.

A registered set of condition flags (carry, overflow, sign, zero) comes with every result. A sticky saturation bit records that at least one clamp has happened since it was last cleared. Results, flags and the sticky bit change only on cycles where the operation strobe is high. The one exception is the sticky bit, which an explicit clear input can also reset.

The sticky bit is held by a two-state machine:
- `ST_CLEAN` moves to `ST_SATURATED` on a valid overflowing operation (transition *saturate*).
- `ST_SATURATED` moves to `ST_CLEAN` on a clear when no overflow happens in the same cycle (transition *clear*).
- In every other case the state holds (transition *hold*).

The sticky output is high exactly in `ST_SATURATED`. The operand width is the parameter `WIDTH`, which defaults to 32.

Top module: `sat_addsub_unit`

## Requirements
- R1: With `op_valid`=1 and `op_sub`=0 and no overflow, `res_q` after the next rising clock edge equals `opnd_a + opnd_b` modulo 2^WIDTH.
- R2: With `op_valid`=1 and `op_sub`=1 and no overflow, `res_q` after the next rising clock edge equals `opnd_b - opnd_a` modulo 2^WIDTH.
- R3: When the true signed result exceeds the positive limit, `res_q` becomes 0 followed by WIDTH-1 ones (32'h7FFF_FFFF at the default width).
- R4: When the true signed result is below the negative limit, `res_q` becomes 1 followed by WIDTH-1 zeros (32'h8000_0000 at the default width).
- R5: `flag_v` is 1 exactly when the signed operation overflowed; it then comes with a clamped `res_q`.
- R6: `flag_s` equals the most significant bit of the delivered (clamped) result, and `flag_z` is 1 exactly when the delivered result is zero.
- R7: `flag_c` is the unsigned carry out of the addition, or for subtraction the unsigned borrow, which is 1 when `opnd_b` < `opnd_a` as unsigned numbers.
- R8: A valid overflowing operation sets `sat_sticky`. Later non-overflowing operations leave it set.
- R9: `sat_clr`=1 clears `sat_sticky` at the next edge, whether or not `op_valid` is high. If a valid overflow occurs in the same cycle, the sticky bit is set instead.
- R10: While `op_valid`=0, `res_q` and all four flags hold their values, and the operand and select inputs have no effect.
- R11: After reset, `res_q`, all four flags and `sat_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe; enables result and flag update |
| op_sub | input | 1 | 0 selects A+B, 1 selects B−A |
| opnd_a | input | WIDTH | Operand A (addend or subtrahend) |
| opnd_b | input | WIDTH | Operand B (addend or minuend) |
| sat_clr | input | 1 | Clears the sticky saturation bit |
| res_q | output | WIDTH | Registered, saturated result |
| flag_c | output | 1 | Unsigned carry (add) or borrow (subtract) |
| flag_v | output | 1 | Signed overflow of the raw operation |
| flag_s | output | 1 | Sign of the delivered result |
| flag_z | output | 1 | Delivered result equals zero |
| sat_sticky | output | 1 | Sticky saturation record |

## Verification
The bench sweeps every operand pair in both modes at a 6-bit width. This covers the exact boundaries where one more unit crosses into overflow, and subtracting the most negative value, which an ordinary negate-and-add overflow check gets wrong. A design that picked the true sign from the raw result, or that took the subtrahend from the wrong operand, would clamp to the opposite extreme or miss the overflow. A design that computed carry from the signed result or inverted the borrow would show a wrong `flag_c`. Idle cycles with changing operands, and clears that arrive both alone and together with an overflow, expose a result register that is not gated by the strobe and a clear that wrongly beats a fresh saturation.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic {
        ST_CLEAN     = 1'b0,
        ST_SATURATED = 1'b1
    } sticky_state_e;

    typedef struct packed {
        logic c;
        logic v;
        logic s;
        logic z;
    } cond_flags_t;

endpackage

// File: rtl/sat_arith.sv
module sat_arith #(
    parameter int WIDTH = 32
) (
    input  logic             op_sub,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] raw,
    output logic             carry,
    output logic             ovf,
    output logic             true_neg
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] ext_sum;
    logic [WIDTH:0] ext_diff;

    always_comb begin
        ext_sum  = {1'b0, opnd_a} + {1'b0, opnd_b};
        ext_diff = {1'b0, opnd_b} - {1'b0, opnd_a};
        if (op_sub) begin
            raw      = ext_diff[MSB:0];
            carry    = ext_diff[WIDTH];
            // b - a overflows only when the signs differ and the result
            // sign departs from the minuend's sign
            ovf      = (opnd_b[MSB] != opnd_a[MSB]) && (ext_diff[MSB] != opnd_b[MSB]);
            true_neg = opnd_b[MSB];
        end else begin
            raw      = ext_sum[MSB:0];
            carry    = ext_sum[WIDTH];
            ovf      = (opnd_a[MSB] == opnd_b[MSB]) && (ext_sum[MSB] != opnd_a[MSB]);
            true_neg = opnd_a[MSB];
        end
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
    import sat_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] raw,
    input  logic             carry,
    input  logic             ovf,
    input  logic             true_neg,
    output logic [WIDTH-1:0] res,
    output cond_flags_t      flags
);
    localparam logic [WIDTH-1:0] POS_LIMIT = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] NEG_LIMIT = {1'b1, {(WIDTH-1){1'b0}}};

    always_comb begin
        if (!ovf)          res = raw;
        else if (true_neg) res = NEG_LIMIT;
        else               res = POS_LIMIT;
        flags.c = carry;
        flags.v = ovf;
        flags.s = res[WIDTH-1];
        flags.z = (res == '0);
    end
endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
    import sat_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_sub,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             sat_clr,
    output logic [WIDTH-1:0] res_q,
    output logic             flag_c,
    output logic             flag_v,
    output logic             flag_s,
    output logic             flag_z,
    output logic             sat_sticky
);
    logic [WIDTH-1:0] raw_w;
    logic             carry_w;
    logic             ovf_w;
    logic             neg_w;
    logic [WIDTH-1:0] res_w;
    cond_flags_t      flags_w;
    cond_flags_t      flags_q;
    sticky_state_e    state_q;
    sticky_state_e    state_d;
    logic             sat_event;

    sat_arith #(.WIDTH(WIDTH)) u_arith (
        .op_sub   (op_sub),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .raw      (raw_w),
        .carry    (carry_w),
        .ovf      (ovf_w),
        .true_neg (neg_w)
    );

    sat_clamp #(.WIDTH(WIDTH)) u_clamp (
        .raw      (raw_w),
        .carry    (carry_w),
        .ovf      (ovf_w),
        .true_neg (neg_w),
        .res      (res_w),
        .flags    (flags_w)
    );

    assign sat_event = op_valid && ovf_w;

    // sticky state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAN;
        else        state_q <= state_d;
    end

    // next state: saturate beats clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: begin
                if (sat_event) state_d = ST_SATURATED;
            end
            ST_SATURATED: begin
                if (sat_clr && !sat_event) state_d = ST_CLEAN;
            end
            default: state_d = ST_CLEAN;
        endcase
    end

    // result and flag registers, gated by the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (op_valid) begin
            res_q   <= res_w;
            flags_q <= flags_w;
        end
    end

    always_comb begin
        flag_c     = flags_q.c;
        flag_v     = flags_q.v;
        flag_s     = flags_q.s;
        flag_z     = flags_q.z;
        sat_sticky = (state_q == ST_SATURATED);
    end
endmodule

// File: rtl/sat_addsub_unit_chk.sv
module sat_addsub_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             sat_clr,
    input logic [WIDTH-1:0] res_q,
    input logic             flag_v,
    input logic             flag_s,
    input logic             flag_z,
    input logic             sat_sticky
);
    localparam logic [WIDTH-1:0] POS_LIMIT = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] NEG_LIMIT = {1'b1, {(WIDTH-1){1'b0}}};

    // R5: an overflow flag always comes with a clamped result (R3, R4)
    a_r5_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        flag_v |-> (res_q == POS_LIMIT || res_q == NEG_LIMIT));

    // R6: sign flag follows the delivered result
    a_r6_sign: assert property (@(posedge clk) disable iff (!rst_n)
        flag_s == res_q[WIDTH-1]);

    // R8: a fresh overflow is recorded in the sticky bit
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_v) |-> sat_sticky);

    // R8: without a clear the sticky bit never drops
    a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_sticky && !sat_clr) |=> sat_sticky);

    // R9: a clear while idle empties the sticky bit
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clr && !op_valid) |=> !sat_sticky);

    // R10: idle cycles hold result and flags
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(res_q) && $stable(flag_v) && $stable(flag_z)));
endmodule

bind sat_addsub_unit sat_addsub_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .sat_clr    (sat_clr),
    .res_q      (res_q),
    .flag_v     (flag_v),
    .flag_s     (flag_s),
    .flag_z     (flag_z),
    .sat_sticky (sat_sticky)
);

// File: tb/sat_addsub_unit_test.sv
module sat_addsub_unit_test;
    localparam int W    = 6;
    localparam int SPAN = 1 << W;
    localparam int PMAX = (1 << (W - 1)) - 1;
    localparam int NMIN = -(1 << (W - 1));

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic         op_sub = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         sat_clr = 1'b0;
    logic [W-1:0] res_q;
    logic         flag_c, flag_v, flag_s, flag_z, sat_sticky;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model state
    int m_res = 0;
    bit m_c = 0, m_v = 0, m_s = 0, m_z = 0, m_st = 0;

    always #10 clk = ~clk;  // 50 MHz

    sat_addsub_unit #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_clr(sat_clr),
        .res_q(res_q), .flag_c(flag_c), .flag_v(flag_v), .flag_s(flag_s),
        .flag_z(flag_z), .sat_sticky(sat_sticky)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (sub=%0b a=%0d b=%0d)",
                     req, act, exp, op_sub, opnd_a, opnd_b);
        end
    endtask

    // drive one cycle at a falling edge, check after the following falling edge
    task automatic step(input bit v, input bit sub, input int a, input int b, input bit clr);
        int sa, sb, tr, ures;
        bit ovf, cy;
        string rtag;
        op_valid = v; op_sub = sub; sat_clr = clr;
        opnd_a = W'(a); opnd_b = W'(b);
        sa = (a >= SPAN/2) ? a - SPAN : a;
        sb = (b >= SPAN/2) ? b - SPAN : b;
        tr = sub ? sb - sa : sa + sb;
        ovf = (tr > PMAX) || (tr < NMIN);
        cy  = sub ? (b < a) : ((a + b) >= SPAN);
        rtag = sub ? "R2" : "R1";
        if (tr > PMAX) rtag = "R3";
        if (tr < NMIN) rtag = "R4";
        if (v) begin
            ures = ovf ? ((tr > PMAX) ? PMAX : SPAN/2) : ((tr % SPAN + SPAN) % SPAN);
            m_res = ures; m_c = cy; m_v = ovf;
            m_s = (ures >= SPAN/2); m_z = (ures == 0);
        end else begin
            rtag = "R10";
        end
        if (v && ovf) m_st = 1'b1;
        else if (clr) m_st = 1'b0;
        @(negedge clk);
        check(rtag, int'(res_q), m_res);
        check(v ? "R5" : "R10", int'(flag_v), int'(m_v));
        check(v ? "R6" : "R10", int'({flag_s, flag_z}), int'({m_s, m_z}));
        check(v ? "R7" : "R10", int'(flag_c), int'(m_c));
        check(clr ? "R9" : "R8", int'(sat_sticky), int'(m_st));
    endtask

    initial begin
        int n = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", int'(res_q), 0);
        check("R11", int'({flag_c, flag_v, flag_s, flag_z}), 0);
        check("R11", int'(sat_sticky), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < SPAN; a++) begin
                for (int b = 0; b < SPAN; b++) begin
                    n++;
                    step(1'b1, s[0], a, b, (n % 23) == 0);
                    if ((n % 13) == 0)
                        step(1'b0, ~s[0], b, a, (n % 26) == 0);
                end
            end
        end
        // R9: clear coinciding with an overflow keeps the bit set
        step(1'b1, 1'b0, PMAX, 1, 1'b1);
        step(1'b1, 1'b0, 1, 1, 1'b0);
        step(1'b0, 1'b0, 0, 0, 1'b1);
        // R8: set, then non-overflowing operations keep it
        step(1'b1, 1'b1, 1, SPAN/2, 1'b0);
        step(1'b1, 1'b0, 2, 3, 1'b0);
        step(1'b1, 1'b1, 3, 3, 1'b0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule